// File: doc/BRIEF.md
# Kinetic Synaptic Current Integrator

This block computes the current of a single chemical synapse whose receptors follow first-order kinetics. It takes the presynaptic membrane value as a signed number. From its sign it derives a transmitter-release flag, and on every update strobe it advances the synaptic current by one explicit Euler step. While release is active, the current charges toward full scale. While release is off, the current discharges toward zero. Charge and discharge have separate rates.

Release is judged from the membrane value itself and not from a uniform spike event. A wide or tall presynaptic excursion therefore keeps release on for more steps and drives the current higher. The block also counts the steps of the release window that is in progress. When that window closes, it reports the final length with a one-cycle valid pulse. Neuron-network logic around the block can use this length as a measure of presynaptic spike magnitude. Weighting, summing over synapses and learning are left to other blocks.

Top module: `syn_current_integ`

## Requirements
- R1: On a strobe cycle (`step_en`=1), `rel_out` takes 1 if the signed `v_pre` is strictly greater than zero, and 0 if it is zero or negative.
- R2: `is_cur` is an unsigned fraction in which the value 2^IW stands for 1.0, and it stays within 0 to 2^IW inclusive.
- R3: On a strobe cycle with `v_pre` > 0, `is_cur` becomes is + ((2^IW − is) >> ALPHA_SH), clamped to 2^IW.
- R4: On a strobe cycle with `v_pre` ≤ 0, `is_cur` becomes is − (is >> BETA_SH).
- R5: On the strobe where release goes from 1 to 0, `len_out` takes the release-step count reached so far. `len_vld` is then high for exactly one clock cycle. It is never high otherwise.
- R6: `run_len` is the number of strobes in the current release window, counting the strobe that started it (1 after the first). It is 0 after any strobe without release.
- R7: `run_len` saturates at 2^CW − 1 and holds there while release continues.
- R8: Without a strobe, `is_cur`, `rel_out`, `run_len` and `len_out` hold their values whatever `v_pre` does.
- R9: A synchronous active-high `rst` clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Update strobe, one Euler step per high cycle |
| v_pre | input | VW | Presynaptic membrane value, signed two's complement |
| is_cur | output | IW+1 | Synaptic current, 2^IW stands for 1.0 |
| rel_out | output | 1 | Transmitter-release flag of the last step |
| run_len | output | CW | Steps spent in the current release window |
| len_out | output | CW | Length of the last finished release window |
| len_vld | output | 1 | One-cycle pulse when `len_out` is updated |

## Verification
The current is driven with release pulses of width 1 to 5 steps, at the smallest and the largest positive membrane value. These runs separate "release depends on sign only" from any magnitude scaling, and show that the charge step depends on the stored current. Zero and negative inputs separate the strict threshold from a greater-or-equal test. A release window longer than 2^CW − 1 steps exercises counter saturation. A long silent stretch follows, where the floor-shift discharge flattens out. Between strobes the membrane input is toggled to show that nothing moves without `step_en`.

// File: rtl/syn_pkg.sv
package syn_pkg;

    localparam int SYN_VW       = 10;
    localparam int SYN_IW       = 12;
    localparam int SYN_ALPHA_SH = 3;
    localparam int SYN_BETA_SH  = 5;
    localparam int SYN_CW       = 6;

    typedef struct packed {
        logic step;
        logic rel;
        logic fall;
    } rel_ev_t;

endpackage

// File: rtl/syn_release_det.sv
module syn_release_det
    import syn_pkg::*;
#(
    parameter int VW = SYN_VW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic [VW-1:0] v_pre,
    output rel_ev_t       ev,
    output logic          rel_q
);

    logic rel_now;

    always_comb begin
        rel_now = $signed(v_pre) > $signed({VW{1'b0}});
        ev.step = step_en;
        ev.rel  = rel_now;
        ev.fall = step_en & rel_q & ~rel_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_q <= 1'b0;
        end else if (step_en) begin
            rel_q <= rel_now;
        end
    end

endmodule

// File: rtl/syn_kinetic_step.sv
module syn_kinetic_step
    import syn_pkg::*;
#(
    parameter int IW       = SYN_IW,
    parameter int ALPHA_SH = SYN_ALPHA_SH,
    parameter int BETA_SH  = SYN_BETA_SH
) (
    input  logic      clk,
    input  logic      rst,
    input  rel_ev_t   ev,
    output logic [IW:0] is_cur
);

    localparam logic [IW:0] ONE = (IW+1)'(1) << IW;

    logic [IW:0] is_q;
    logic [IW:0] gap;
    logic [IW+1:0] rise_wide;
    logic [IW:0] rise_v;
    logic [IW:0] fall_v;

    always_comb begin
        gap       = ONE - is_q;
        rise_wide = {1'b0, is_q} + {1'b0, (gap >> ALPHA_SH)};
        if (rise_wide > {1'b0, ONE}) begin
            rise_v = ONE;
        end else begin
            rise_v = rise_wide[IW:0];
        end
        fall_v = is_q - (is_q >> BETA_SH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            is_q <= '0;
        end else if (ev.step) begin
            is_q <= ev.rel ? rise_v : fall_v;
        end
    end

    assign is_cur = is_q;

endmodule

// File: rtl/syn_run_counter.sv
module syn_run_counter
    import syn_pkg::*;
#(
    parameter int CW = SYN_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  rel_ev_t       ev,
    output logic [CW-1:0] run_len,
    output logic [CW-1:0] len_out,
    output logic          len_vld
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            len_out <= '0;
            len_vld <= 1'b0;
        end else begin
            len_vld <= 1'b0;
            if (ev.step) begin
                if (ev.rel) begin
                    if (run_len != CNT_MAX) begin
                        run_len <= run_len + 1'b1;
                    end
                end else begin
                    run_len <= '0;
                    if (ev.fall) begin
                        len_out <= run_len;
                        len_vld <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/syn_current_integ.sv
module syn_current_integ
    import syn_pkg::*;
#(
    parameter int VW       = SYN_VW,
    parameter int IW       = SYN_IW,
    parameter int ALPHA_SH = SYN_ALPHA_SH,
    parameter int BETA_SH  = SYN_BETA_SH,
    parameter int CW       = SYN_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic [VW-1:0] v_pre,
    output logic [IW:0]   is_cur,
    output logic          rel_out,
    output logic [CW-1:0] run_len,
    output logic [CW-1:0] len_out,
    output logic          len_vld
);

    rel_ev_t ev;

    syn_release_det #(.VW(VW)) u_det (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .v_pre   (v_pre),
        .ev      (ev),
        .rel_q   (rel_out)
    );

    syn_kinetic_step #(.IW(IW), .ALPHA_SH(ALPHA_SH), .BETA_SH(BETA_SH)) u_kin (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .is_cur (is_cur)
    );

    syn_run_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .run_len (run_len),
        .len_out (len_out),
        .len_vld (len_vld)
    );

endmodule

// File: rtl/syn_current_integ_chk.sv
module syn_current_integ_chk #(
    parameter int VW = 10,
    parameter int IW = 12,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          step_en,
    input logic [VW-1:0] v_pre,
    input logic [IW:0]   is_cur,
    input logic          rel_out,
    input logic [CW-1:0] run_len,
    input logic [CW-1:0] len_out,
    input logic          len_vld
);

    localparam logic [IW:0]   ONE     = (IW+1)'(1) << IW;
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic pos_in;
    assign pos_in = $signed(v_pre) > $signed({VW{1'b0}});

    p_bounded_r2: assert property (@(posedge clk) disable iff (rst)
        is_cur <= ONE);

    p_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (step_en && pos_in) |=> (is_cur >= $past(is_cur)));

    p_decay_r4: assert property (@(posedge clk) disable iff (rst)
        (step_en && !pos_in) |=> (is_cur <= $past(is_cur)));

    p_rel_r1: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (rel_out == $past(pos_in)));

    p_vld_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        len_vld |=> !len_vld);

    p_vld_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (step_en && rel_out && !pos_in) |=> len_vld);

    p_cnt_sat_r7: assert property (@(posedge clk) disable iff (rst)
        (step_en && pos_in && run_len == CNT_MAX) |=> (run_len == CNT_MAX));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(is_cur) && $stable(rel_out) && $stable(run_len) && $stable(len_out)));

endmodule

bind syn_current_integ syn_current_integ_chk #(.VW(VW), .IW(IW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .v_pre   (v_pre),
    .is_cur  (is_cur),
    .rel_out (rel_out),
    .run_len (run_len),
    .len_out (len_out),
    .len_vld (len_vld)
);

// File: tb/syn_current_integ_bench.sv
module syn_current_integ_bench;

    localparam int VW = 10;
    localparam int IW = 12;
    localparam int ASH = 3;
    localparam int BSH = 5;
    localparam int CW = 6;
    localparam int ONE = 1 << IW;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          step_en = 1'b0;
    logic [VW-1:0] v_pre = '0;
    logic [IW:0]   is_cur;
    logic          rel_out;
    logic [CW-1:0] run_len;
    logic [CW-1:0] len_out;
    logic          len_vld;

    int n_chk = 0;
    int n_fail = 0;

    int e_is = 0;
    int e_rel = 0;
    int e_run = 0;
    int e_len = 0;
    int e_vld = 0;

    always #2.5 clk = ~clk;

    syn_current_integ #(.VW(VW), .IW(IW), .ALPHA_SH(ASH), .BETA_SH(BSH), .CW(CW)) u_syn_current_integ (
        .clk(clk), .rst(rst), .step_en(step_en), .v_pre(v_pre),
        .is_cur(is_cur), .rel_out(rel_out), .run_len(run_len),
        .len_out(len_out), .len_vld(len_vld)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R1 rel_out"}, int'(rel_out), e_rel);
        chk({tag, " R2/R3/R4 is_cur"}, int'(is_cur), e_is);
        chk({tag, " R6/R7 run_len"}, int'(run_len), e_run);
        chk({tag, " R5 len_vld"}, int'(len_vld), e_vld);
        chk({tag, " R5 len_out"}, int'(len_out), e_len);
    endtask

    // One strobe with membrane value v; model advanced from the requirements.
    task automatic do_step(input int v, input string tag);
        int pos;
        @(negedge clk);
        v_pre = VW'(v);
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        pos = (v > 0) ? 1 : 0;
        e_vld = 0;
        if (pos == 1) begin
            e_is = e_is + ((ONE - e_is) >>> ASH);   // R3
            if (e_is > ONE) e_is = ONE;
            e_run = (e_run == CMAX) ? CMAX : e_run + 1;   // R6, R7
        end else begin
            e_is = e_is - (e_is >>> BSH);           // R4
            if (e_rel == 1) begin
                e_len = e_run;                      // R5
                e_vld = 1;
            end
            e_run = 0;
        end
        e_rel = pos;
        check_all(tag);
    endtask

    initial begin : watchdog
        #500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R9 reset");

        // R1: zero and negative inputs never release
        do_step(0, "zero");
        do_step(-1, "neg");
        do_step(-512, "minneg");

        // Pulse widths 1..5, small and full-scale heights
        for (int w = 1; w <= 5; w++) begin
            for (int h = 0; h < 2; h++) begin
                for (int k = 0; k < w; k++) do_step(h == 0 ? 1 : 511, "pulse");
                do_step(h == 0 ? 0 : -3, "pulse end");
                do_step(-7, "gap");
            end
        end

        // R8: input moves without strobe, nothing changes
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            v_pre = VW'((k % 2 == 0) ? 300 : -300);
        end
        @(negedge clk);
        e_vld = 0;
        check_all("R8 hold");
        do_step(5, "R8 after");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            v_pre = VW'(-100);
        end
        @(negedge clk);
        e_vld = 0;
        check_all("R8 hold during release");

        // R7: long release saturates the counter; Is approaches one
        for (int k = 0; k < 80; k++) do_step(200, "R7 long");
        do_step(0, "R7 end");
        chk("R7 saturated len", int'(len_out), CMAX);

        // Long silent decay
        for (int k = 0; k < 300; k++) do_step(-50, "R4 decay");

        // R9: reset mid-release
        for (int k = 0; k < 3; k++) do_step(100, "pre-reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        e_is = 0; e_rel = 0; e_run = 0; e_len = 0; e_vld = 0;
        @(negedge clk);
        check_all("R9 reset mid-run");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule